// File: doc/BRIEF.md
# DMA Bus Arbiter with Weighted Priority Fairness

This block decides, one transaction at a time, which requester owns a shared bus: the processor or one of `NUM_CH` DMA channels. Every channel carries a 3-bit urgency level, where 0 is the most urgent and 7 the least. Each channel also has a switch that lets it take part in, or stay out of, rotating tie-breaks among channels at the same level. A new owner is chosen only when the bus is idle or when the current transaction signals its last cycle. A grant therefore never changes in the middle of a transaction.

The processor is favoured over DMA, but a guard stops it from keeping the bus for ever. A global fairness switch sets how the less urgent levels share bus slots. With the switch on, levels 2 to 7 each own a fixed, binary-weighted fraction of the DMA slots that levels 0 and 1 leave unused. With the switch off, the most urgent requesting level always wins. The data path, descriptor fetch and address routing belong to other blocks.

Top module: `dma_bus_arbiter`

## Requirements
- R1: While `rst_n` is low and in the first cycle after it rises, `cpu_gnt`, `ch_gnt` and `gnt_valid` are all 0. Every round-robin pointer starts at channel 0, and the slot counter and starvation count start at 0.
- R2: At most one of `cpu_gnt` and the bits of `ch_gnt` is 1. `gnt_valid` is their OR. When a channel holds the grant, `gnt_idx` is that channel's number; otherwise `gnt_idx` is 0.
- R3: A decision is made on a clock edge where `gnt_valid` is 0 or `xfer_done` is 1. On any other edge all grant outputs keep their values, even if a more urgent requester appears.
- R4: At a decision, if `cpu_req` is 1 the processor is granted, unless R5 forces a DMA grant.
- R5: A starvation count rises at each decision that grants the processor while some `ch_req` bit is set, and returns to 0 at every other decision. At a decision where the count equals `STARVE_LIMIT` (default 16) and DMA is pending, a channel is granted instead of the processor.
- R6: With `fair_en` at 0, a DMA decision picks the lowest-numbered level that has a request. Channel i's level is `ch_prio[3*i+2:3*i]`.
- R7: A request at level 0 or 1 always beats requests at levels 2 to 7, whatever `fair_en` is.
- R8: A 6-bit slot counter advances by one at each DMA decision taken with `fair_en` at 1 and no level 0 or 1 request. For a nonzero counter value v with t trailing zeros, level 2+min(t,5) owns the slot. If the owner has a request it is chosen. If the owner has none, or v is 0, the lowest requesting level is chosen.
- R9: Among requesting channels of the chosen level whose `ch_rr_en` is 1, the first one found when scanning upward from that level's pointer, wrapping around, is granted. When such a channel c is granted, the pointer moves to c+1 (mod `NUM_CH`). Pointers of other levels do not move.
- R10: A requesting channel whose `ch_rr_en` is 0 beats round-robin channels at its own level. Among several such channels, the lowest index wins. Its grant leaves the pointer unchanged.
- R11: A grant goes only to a requester that was asserting its request at the deciding edge. A decision with no request leaves all grants at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| cpu_req | input | 1 | Processor requests the bus |
| ch_req | input | NUM_CH | Per-channel DMA request |
| ch_prio | input | 3*NUM_CH | Per-channel level, 3 bits each, channel 0 in the low bits |
| ch_rr_en | input | NUM_CH | 1 = channel takes part in rotating tie-break |
| fair_en | input | 1 | 1 = weighted slot sharing for levels 2 to 7 |
| xfer_done | input | 1 | Current transaction ends in this cycle |
| cpu_gnt | output | 1 | Processor owns the bus |
| ch_gnt | output | NUM_CH | One-hot channel grant |
| gnt_idx | output | $clog2(NUM_CH) | Number of the granted channel |
| gnt_valid | output | 1 | Some requester owns the bus |

## Verification
The bench keeps the processor requesting for long stretches. An arbiter without a working guard would then hand it every slot and never reach a channel. Another arbiter might release the guard one decision too early or too late, and the exact-cycle comparison catches that. Under fairness, all six low-urgency levels request together for 64 decisions, and the bench counts grants per level. A wrong trailing-zero mapping, or a counter that also steps on level 0/1 traffic, changes those counts. Multi-cycle transactions are opened and then hit with more urgent requests, which exposes an arbiter that re-decides mid-transfer. Mixes of round-robin and opt-out channels at one level show up a pointer that moves on opt-out grants or skips a channel when it wraps.

// File: rtl/dma_arb_pkg.sv
// Shared constants for the DMA bus arbiter.
// Assumes 3-bit urgency levels, with 0 the most urgent.
package dma_arb_pkg;
    localparam int PRIO_W   = 3;
    localparam int NUM_LVL  = 1 << PRIO_W;
    localparam int FAIR_MIN = 2;        // first level that takes part in slot sharing
    localparam int FAIR_MAX = NUM_LVL - 1;
endpackage

// File: rtl/dma_arb_slot_sched.sv
// Fairness slot schedule: a free-running counter whose trailing-zero count
// names the level that owns the current slot. A value of zero names nobody.
// Assumes SLOT_W >= FAIR_MAX - FAIR_MIN + 1 so that every fair level owns a slot.
module dma_arb_slot_sched
    import dma_arb_pkg::*;
#(
    parameter int SLOT_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              advance,
    output logic              slot_live,
    output logic [PRIO_W-1:0] slot_lvl
);
    localparam int TZ_W   = $clog2(SLOT_W + 1);
    localparam int TZ_CAP = FAIR_MAX - FAIR_MIN;

    logic [SLOT_W-1:0] slot_q;
    logic [TZ_W-1:0]   tz;

    // Counter steps once for each slot handed to the fair levels.
    always_ff @(posedge clk) begin
        if (!rst_n)       slot_q <= '0;
        else if (advance) slot_q <= slot_q + 1'b1;
    end

    // Trailing-zero count: position of the lowest set bit.
    always_comb begin
        tz = '0;
        for (int i = SLOT_W - 1; i >= 0; i--) begin
            if (slot_q[i]) tz = TZ_W'(i);
        end
    end

    // Map the trailing-zero count to the owning level; saturate at the least urgent.
    always_comb begin
        slot_live = (slot_q != '0);
        if (int'(tz) >= TZ_CAP) slot_lvl = PRIO_W'(FAIR_MAX);
        else                    slot_lvl = PRIO_W'(int'(tz) + FAIR_MIN);
    end
endmodule

// File: rtl/dma_arb_level_rr.sv
// Tie-break among the requesting channels of one level. Opt-out channels
// (rotation disabled) win first, lowest index. Otherwise the scan starts at
// the rotation pointer and wraps. The pointer moves only on a take.
// Assumes lvl_req is already masked to this level.
module dma_arb_level_rr #(
    parameter int NUM_CH = 8,
    parameter int IDX_W  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_CH-1:0] lvl_req,
    input  logic [NUM_CH-1:0] rr_en,
    input  logic              take,
    input  logic [IDX_W-1:0]  take_idx,
    output logic              hit,
    output logic [IDX_W-1:0]  pick_idx
);
    logic [IDX_W-1:0]  ptr_q;
    logic [NUM_CH-1:0] fixed_req;
    logic              fixed_hit;
    logic [IDX_W-1:0]  fixed_idx;
    logic [IDX_W-1:0]  rot_idx;

    assign fixed_req = lvl_req & ~rr_en;
    assign fixed_hit = |fixed_req;
    assign hit       = |lvl_req;

    // Lowest-index opt-out requester.
    always_comb begin
        fixed_idx = '0;
        for (int i = NUM_CH - 1; i >= 0; i--) begin
            if (fixed_req[i]) fixed_idx = IDX_W'(i);
        end
    end

    // First rotating requester at or after the pointer, wrapping.
    always_comb begin
        rot_idx = '0;
        for (int k = NUM_CH - 1; k >= 0; k--) begin
            int j;
            j = int'(ptr_q) + k;
            if (j >= NUM_CH) j = j - NUM_CH;
            if (lvl_req[j] && rr_en[j]) rot_idx = IDX_W'(j);
        end
    end

    // Final choice for this level.
    assign pick_idx = fixed_hit ? fixed_idx : rot_idx;

    // Rotation pointer moves just past the channel that was taken.
    always_ff @(posedge clk) begin
        if (!rst_n)    ptr_q <= '0;
        else if (take) ptr_q <= (int'(take_idx) == NUM_CH - 1) ? '0 : take_idx + 1'b1;
    end
endmodule

// File: rtl/dma_arb_starve_guard.sv
// Counts back-to-back processor wins while DMA waits, and forces one DMA win
// when the count reaches STARVE_LIMIT. Assumes decide marks arbitration edges.
module dma_arb_starve_guard #(
    parameter int STARVE_LIMIT = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic decide,
    input  logic cpu_req,
    input  logic dma_any,
    output logic force_dma
);
    localparam int CNT_W = $clog2(STARVE_LIMIT + 1);

    logic [CNT_W-1:0] run_q;

    assign force_dma = (run_q == CNT_W'(STARVE_LIMIT));

    // Run length of processor wins over waiting DMA; cleared by any other outcome.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_q <= '0;
        end else if (decide) begin
            if (cpu_req && dma_any && !force_dma) run_q <= run_q + 1'b1;
            else                                  run_q <= '0;
        end
    end
endmodule

// File: rtl/dma_bus_arbiter.sv
// Transaction-granular bus arbiter: processor first (with a starvation guard),
// then DMA channels by level, with optional weighted slot sharing for levels
// 2..7 and per-level round-robin. Assumes xfer_done is asserted by the owner
// in the final cycle of each transaction.
module dma_bus_arbiter
    import dma_arb_pkg::*;
#(
    parameter int NUM_CH       = 8,
    parameter int STARVE_LIMIT = 16,
    parameter int SLOT_W       = 6,
    localparam int IDX_W       = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     cpu_req,
    input  logic [NUM_CH-1:0]        ch_req,
    input  logic [PRIO_W*NUM_CH-1:0] ch_prio,
    input  logic [NUM_CH-1:0]        ch_rr_en,
    input  logic                     fair_en,
    input  logic                     xfer_done,
    output logic                     cpu_gnt,
    output logic [NUM_CH-1:0]        ch_gnt,
    output logic [IDX_W-1:0]         gnt_idx,
    output logic                     gnt_valid
);
    logic [NUM_CH-1:0]  lvl_req [NUM_LVL];
    logic [IDX_W-1:0]   lvl_pick [NUM_LVL];
    logic [NUM_LVL-1:0] lvl_hit;
    logic [NUM_LVL-1:0] lvl_take;

    logic              decide, dma_any, urgent_hit, force_dma;
    logic              cpu_win, dma_win, slot_adv, slot_live;
    logic [PRIO_W-1:0] slot_lvl, sel_lvl;
    logic [IDX_W-1:0]  sel_idx;

    logic              cpu_q;
    logic [NUM_CH-1:0] gnt_q;
    logic [IDX_W-1:0]  idx_q;

    assign decide     = !gnt_valid || xfer_done;
    assign dma_any    = |ch_req;
    assign urgent_hit = lvl_hit[0] | lvl_hit[1];

    // Split requests per level and give each level its own tie-break.
    for (genvar l = 0; l < NUM_LVL; l++) begin : g_lvl
        for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
            assign lvl_req[l][c] = ch_req[c] && (ch_prio[c*PRIO_W +: PRIO_W] == PRIO_W'(l));
        end
        assign lvl_take[l] = decide && dma_win && (sel_lvl == PRIO_W'(l)) && ch_rr_en[lvl_pick[l]];
        dma_arb_level_rr #(.NUM_CH(NUM_CH), .IDX_W(IDX_W)) u_rr (
            .clk      (clk),
            .rst_n    (rst_n),
            .lvl_req  (lvl_req[l]),
            .rr_en    (ch_rr_en),
            .take     (lvl_take[l]),
            .take_idx (lvl_pick[l]),
            .hit      (lvl_hit[l]),
            .pick_idx (lvl_pick[l])
        );
    end

    dma_arb_slot_sched #(.SLOT_W(SLOT_W)) u_slot (
        .clk       (clk),
        .rst_n     (rst_n),
        .advance   (slot_adv),
        .slot_live (slot_live),
        .slot_lvl  (slot_lvl)
    );

    dma_arb_starve_guard #(.STARVE_LIMIT(STARVE_LIMIT)) u_guard (
        .clk       (clk),
        .rst_n     (rst_n),
        .decide    (decide),
        .cpu_req   (cpu_req),
        .dma_any   (dma_any),
        .force_dma (force_dma)
    );

    // Processor first, unless the guard hands this decision to DMA.
    assign cpu_win  = cpu_req && !(force_dma && dma_any);
    assign dma_win  = !cpu_win && dma_any;
    assign slot_adv = decide && dma_win && fair_en && !urgent_hit;

    // Level choice: most urgent requester, overridden by the slot owner under fairness.
    always_comb begin
        sel_lvl = '0;
        for (int l = NUM_LVL - 1; l >= 0; l--) begin
            if (lvl_hit[l]) sel_lvl = PRIO_W'(l);
        end
        if (fair_en && !urgent_hit && slot_live && lvl_hit[slot_lvl]) sel_lvl = slot_lvl;
        sel_idx = lvl_pick[sel_lvl];
    end

    // Grant register, reloaded only at transaction boundaries.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cpu_q <= 1'b0;
            gnt_q <= '0;
            idx_q <= '0;
        end else if (decide) begin
            cpu_q <= cpu_win;
            gnt_q <= dma_win ? (NUM_CH'(1) << sel_idx) : '0;
            idx_q <= dma_win ? sel_idx : '0;
        end
    end

    assign cpu_gnt   = cpu_q;
    assign ch_gnt    = gnt_q;
    assign gnt_idx   = idx_q;
    assign gnt_valid = cpu_q || (|gnt_q);
endmodule

// File: rtl/dma_bus_arbiter_checker.sv
// Protocol checks for dma_bus_arbiter, attached by bind. Looks only at ports,
// plus a run counter of its own for the starvation bound.
module dma_bus_arbiter_checker #(
    parameter int NUM_CH       = 8,
    parameter int IDX_W        = 3,
    parameter int STARVE_LIMIT = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cpu_req,
    input logic [NUM_CH-1:0] ch_req,
    input logic              xfer_done,
    input logic              cpu_gnt,
    input logic [NUM_CH-1:0] ch_gnt,
    input logic [IDX_W-1:0]  gnt_idx,
    input logic              gnt_valid
);
    logic boundary;
    logic dec_d, pend_d;
    int   cpu_run;

    assign boundary = !gnt_valid || xfer_done;

    // Remember what each decision saw, to judge its outcome one edge later.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dec_d   <= 1'b0;
            pend_d  <= 1'b0;
            cpu_run <= 0;
        end else begin
            dec_d  <= boundary;
            pend_d <= |ch_req;
            if (dec_d) cpu_run <= (cpu_gnt && pend_d) ? cpu_run + 1 : 0;
        end
    end

    assert_one_owner_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({cpu_gnt, ch_gnt}));

    assert_valid_or_R2: assert property (@(posedge clk) disable iff (!rst_n)
        gnt_valid == (cpu_gnt || (|ch_gnt)));

    assert_idx_match_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (|ch_gnt) |-> ch_gnt[gnt_idx]);

    assert_hold_mid_xfer_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (gnt_valid && !xfer_done) |=> ($stable(ch_gnt) && $stable(cpu_gnt)));

    assert_cpu_alone_wins_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (boundary && cpu_req && ch_req == '0) |=> cpu_gnt);

    assert_no_starve_R5: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_run <= STARVE_LIMIT);

    assert_only_requesters_R11: assert property (@(posedge clk) disable iff (!rst_n)
        boundary |=> (((ch_gnt & ~$past(ch_req)) == '0) && (!cpu_gnt || $past(cpu_req))));

    assert_idle_when_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (boundary && !cpu_req && ch_req == '0) |=> !gnt_valid);
endmodule

bind dma_bus_arbiter dma_bus_arbiter_checker #(
    .NUM_CH       (NUM_CH),
    .IDX_W        (IDX_W),
    .STARVE_LIMIT (STARVE_LIMIT)
) u_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .cpu_req   (cpu_req),
    .ch_req    (ch_req),
    .xfer_done (xfer_done),
    .cpu_gnt   (cpu_gnt),
    .ch_gnt    (ch_gnt),
    .gnt_idx   (gnt_idx),
    .gnt_valid (gnt_valid)
);

// File: tb/dma_bus_arbiter_tb_top.sv
// Self-checking bench: directed corner cases plus seeded random traffic,
// compared every cycle against a behavioural model kept in bench tasks.
module dma_bus_arbiter_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int NCH        = 8;
    localparam int LIMIT      = 16;

    logic            clk = 1'b0;
    logic            rst_n;
    logic            cpu_req;
    logic [NCH-1:0]  ch_req;
    logic [3*NCH-1:0] ch_prio;
    logic [NCH-1:0]  ch_rr_en;
    logic            fair_en;
    logic            xfer_done;
    logic            cpu_gnt;
    logic [NCH-1:0]  ch_gnt;
    logic [2:0]      gnt_idx;
    logic            gnt_valid;

    int    n_checks = 0;
    int    n_fail   = 0;
    string tag      = "R1";
    bit    finished = 1'b0;

    // Model state.
    bit m_cpu;
    int m_ch;
    int m_slot;
    int m_run;
    int m_ptr [8];
    int lvl_count [8];

    always #(CLK_PERIOD/2) clk = ~clk;

    dma_bus_arbiter #(.NUM_CH(NCH), .STARVE_LIMIT(LIMIT), .SLOT_W(6)) dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .cpu_req   (cpu_req),
        .ch_req    (ch_req),
        .ch_prio   (ch_prio),
        .ch_rr_en  (ch_rr_en),
        .fair_en   (fair_en),
        .xfer_done (xfer_done),
        .cpu_gnt   (cpu_gnt),
        .ch_gnt    (ch_gnt),
        .gnt_idx   (gnt_idx),
        .gnt_valid (gnt_valid)
    );

    function automatic int prio_of(input int c);
        return int'(ch_prio[3*c +: 3]);
    endfunction

    // Owner level of a slot value: 2 + trailing zeros, capped at 7; -1 for zero.
    function automatic int slot_owner(input int v);
        int t = 0;
        if (v == 0) return -1;
        while ((v % 2) == 0) begin
            v = v / 2;
            t++;
        end
        return (t >= 5) ? 7 : 2 + t;
    endfunction

    // Advance the model by one edge using the present inputs.
    task automatic model_edge();
        bit busy = m_cpu || (m_ch >= 0);
        bit any  = (ch_req != '0);
        bit has [8];
        int lvl, pick;
        if (busy && !xfer_done) return;                 // R3
        for (int l = 0; l < 8; l++) has[l] = 1'b0;
        for (int c = 0; c < NCH; c++) if (ch_req[c]) has[prio_of(c)] = 1'b1;
        if (cpu_req && !(any && m_run == LIMIT)) begin  // R4 / R5
            m_cpu = 1'b1;
            m_ch  = -1;
            m_run = any ? m_run + 1 : 0;
            return;
        end
        m_run = 0;
        m_cpu = 1'b0;
        m_ch  = -1;
        if (!any) return;                               // R11
        lvl = 8;
        for (int l = 7; l >= 0; l--) if (has[l]) lvl = l; // R6 / R7
        if (fair_en && !has[0] && !has[1]) begin        // R8
            int own = slot_owner(m_slot);
            if (own >= 0 && has[own]) lvl = own;
            m_slot = (m_slot + 1) % 64;
        end
        pick = -1;
        for (int c = NCH - 1; c >= 0; c--)              // R10
            if (ch_req[c] && !ch_rr_en[c] && prio_of(c) == lvl) pick = c;
        if (pick < 0) begin                             // R9
            for (int k = NCH - 1; k >= 0; k--) begin
                int j = (m_ptr[lvl] + k) % NCH;
                if (ch_req[j] && ch_rr_en[j] && prio_of(j) == lvl) pick = j;
            end
            m_ptr[lvl] = (pick + 1) % NCH;
        end
        m_ch = pick;
    endtask

    task automatic compare();
        logic [NCH-1:0] e_gnt = (m_ch >= 0) ? (NCH'(1) << m_ch) : '0;
        int             e_idx = (m_ch >= 0) ? m_ch : 0;
        bit             e_val = m_cpu || (m_ch >= 0);
        n_checks++;
        if (cpu_gnt !== m_cpu || ch_gnt !== e_gnt || int'(gnt_idx) != e_idx || gnt_valid !== e_val) begin
            n_fail++;
            $display("FAIL %s: got cpu=%0b ch=%h idx=%0d v=%0b, expected cpu=%0b ch=%h idx=%0d v=%0b",
                     tag, cpu_gnt, ch_gnt, gnt_idx, gnt_valid, m_cpu, e_gnt, e_idx, e_val);
        end
        if (ch_gnt != '0) lvl_count[prio_of(int'(gnt_idx))]++;
    endtask

    // One cycle: inputs set at the falling edge, checked at the next falling edge.
    task automatic step(input logic c, input logic [NCH-1:0] r, input logic d);
        cpu_req   = c;
        ch_req    = r;
        xfer_done = d;
        model_edge();
        @(posedge clk);
        @(negedge clk);
        compare();
    endtask

    task automatic set_prio(input int c, input int p);
        ch_prio[3*c +: 3] = 3'(p);
    endtask

    task automatic check_eq(input string t, input int got, input int exp);
        n_checks++;
        if (got != exp) begin
            n_fail++;
            $display("FAIL %s: got %0d expected %0d", t, got, exp);
        end
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: got hung run expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        rst_n = 1'b0; cpu_req = 1'b1; ch_req = '1; fair_en = 1'b0;
        ch_rr_en = '1; xfer_done = 1'b0;
        for (int c = 0; c < NCH; c++) set_prio(c, c);
        m_cpu = 0; m_ch = -1; m_slot = 0; m_run = 0;
        for (int l = 0; l < 8; l++) begin m_ptr[l] = 0; lvl_count[l] = 0; end
        repeat (3) @(negedge clk);
        tag = "R1";
        compare();                                      // R1: idle under reset
        rst_n = 1'b1;
        step(1'b0, '0, 1'b1);                           // R1/R11: nothing requested

        tag = "R4";                                     // R4: processor ahead of urgent DMA
        repeat (4) step(1'b1, 8'h81, 1'b1);
        step(1'b0, 8'h81, 1'b1);

        tag = "R5";                                     // R5: guard hands one slot to DMA
        repeat (40) step(1'b1, 8'h10, 1'b1);
        repeat (20) step(1'b1, 8'h00, 1'b1);

        tag = "R3";                                     // R3: no mid-transaction takeover
        step(1'b0, 8'h20, 1'b0);
        repeat (4) step(1'b1, 8'h21, 1'b0);
        step(1'b1, 8'h21, 1'b1);
        step(1'b0, 8'h21, 1'b1);

        tag = "R6";                                     // R6: strict order without fairness
        for (int k = 0; k < 8; k++) step(1'b0, 8'hFC >> (k % 3), 1'b1);

        tag = "R7";                                     // R7: urgent levels ignore the slot owner
        fair_en = 1'b1;
        repeat (10) step(1'b0, 8'h06, 1'b1);
        repeat (10) step(1'b0, 8'h0D, 1'b1);

        tag = "R8";                                     // R8: weighted sharing over 64 decisions
        for (int l = 0; l < 8; l++) lvl_count[l] = 0;
        repeat (64) step(1'b0, 8'hFC, 1'b1);
        check_eq("R8 level2 share", lvl_count[2], 33);
        check_eq("R8 level3 share", lvl_count[3], 16);
        check_eq("R8 level4 share", lvl_count[4], 8);
        check_eq("R8 level5 share", lvl_count[5], 4);
        check_eq("R8 level6 share", lvl_count[6], 2);
        check_eq("R8 level7 share", lvl_count[7], 1);

        tag = "R9";                                     // R9: rotation within one level
        fair_en = 1'b0;
        for (int c = 0; c < NCH; c++) set_prio(c, 4);
        repeat (12) step(1'b0, 8'hB5, 1'b1);
        repeat (6) step(1'b0, 8'h81, 1'b1);

        tag = "R10";                                    // R10: opt-out channel heads the line
        ch_rr_en = 8'hF7;
        repeat (5) step(1'b0, 8'h0A, 1'b1);
        ch_rr_en = 8'hFF;
        repeat (4) step(1'b0, 8'h0A, 1'b1);

        tag = "R11";                                    // R11 plus all rules: random traffic
        for (int b = 0; b < 15; b++) begin
            fair_en  = 1'($urandom_range(0, 1));
            ch_rr_en = 8'($urandom) | 8'h81;
            for (int c = 0; c < NCH; c++) set_prio(c, $urandom_range(0, 7));
            for (int k = 0; k < 200; k++)
                step(1'($urandom_range(0, 3) == 0), 8'($urandom) & 8'($urandom),
                     1'($urandom_range(0, 9) < 7));
        end

        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule